// File: doc/BRIEF.md
# Seven-Slot Four-Lane Word Serializer

This block turns a 28-bit parallel word into four serial data lanes plus a forwarded clock lane. It runs on a single bit-rate clock. An internal modulo-7 slot counter divides that clock into word periods, and the block flags the last slot of each period on `load_tick`. The word present on `par_data` in that cycle is captured at the next edge. Its bits then leave over the seven slots of the following word period, one bit per lane per slot.

The forwarded clock lane repeats a seven-slot pattern: high for the first four slots and low for the last three. It therefore rises exactly once per word, at the boundary. An active-low `sleep_n` input disables every serial output in the same cycle it goes low. After reset, or after `sleep_n` returns high, the outputs stay disabled for a programmable number of word periods. This models the lock interval of a clock synthesizer. Disabled outputs are driven to a steady idle 0, and `drive_en` tells the pad logic when to enable its drivers.

Top module: `lane_serializer7`

## Requirements
- R1: When `load_tick` is high, all 28 bits of `par_data` are captured together at the next rising edge, which starts a new word period at slot 0.
- R2: In slot s (0..6) of a word period, lane k (bit k of `lane_q`, k = 0..3) carries captured bit 7k+s. Slot 0 therefore carries the lowest bit of each seven-bit group.
- R3: Slots advance by one per clock and wrap from 6 to 0, so `load_tick` is high in exactly one cycle out of every seven. Consecutive words are sent back to back with no idle slot.
- R4: While enabled, `fclk_q` is 1 in slots 0 to 3 and 0 in slots 4 to 6, so it rises only at word boundaries.
- R5: In any cycle where `sleep_n` is 0, `drive_en`, `fclk_q` and every bit of `lane_q` are 0 in that same cycle.
- R6: After reset, and after `sleep_n` goes from 0 to 1, `drive_en` stays 0 until LOCK_WORDS (default 4) `load_tick` edges have passed with `sleep_n` high. It then goes to 1 at the start of slot 0.
- R7: Whenever `drive_en` is 0, `lane_q` is 0 and `fclk_q` is 0.
- R8: While reset is held, the slot counter sits at slot 0, `drive_en` is 0 and all serial outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven cycles per word |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Active-low power-down; low disables all serial outputs |
| par_data | input | 28 | Parallel word, sampled at the edge after `load_tick` |
| load_tick | output | 1 | High in the last slot of each word period |
| lane_q | output | 4 | Serial data lanes, one bit per lane per slot |
| fclk_q | output | 1 | Forwarded clock lane |
| drive_en | output | 1 | Output enable for the serial drivers |

## Verification
The assertions assume that `sleep_n` and `par_data` are synchronous to `clk`. They also assume that `par_data` is valid in the cycle where `load_tick` is high, because the checker compares the first slot of each word against the value it saw one edge earlier. The bench meets both assumptions by changing every input only on falling edges. It presents a new word only while `load_tick` is high and holds it until the next word's slot. Power-down is applied and removed at falling edges, both in the middle of a word and at a boundary, so the same-cycle gating and the re-lock count are each observed on a clean edge.

// File: rtl/lsz_pkg.sv
package lsz_pkg;

    localparam int LSZ_LANES      = 4;
    localparam int LSZ_SLOTS      = 7;
    localparam int LSZ_CLK_HIGH   = 4;
    localparam int LSZ_LOCK_WORDS = 4;

    typedef enum logic {
        LNK_LOCKING = 1'b0,
        LNK_UP      = 1'b1
    } link_state_e;

    // level of the forwarded clock in a given slot
    function automatic logic fclk_level(input int unsigned slot, input int unsigned high_slots);
        return (slot < high_slots);
    endfunction

endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
    parameter int SLOTS     = 7,
    parameter int CLK_HIGH  = 4,
    localparam int SW       = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot_idx,
    output logic          load_tick,
    output logic          fclk_raw
);
    import lsz_pkg::*;

    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_idx <= '0;
        end else if (slot_idx == LAST) begin
            slot_idx <= '0;
        end else begin
            slot_idx <= slot_idx + 1'b1;
        end
    end

    assign load_tick = (slot_idx == LAST);
    assign fclk_raw  = fclk_level(32'(slot_idx), CLK_HIGH);

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SLOTS-1:0] din,
    output logic             dout
);
    logic [SLOTS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= din;
        end else begin
            sh <= {1'b0, sh[SLOTS-1:1]};
        end
    end

    assign dout = sh[0];

endmodule

// File: rtl/link_enable.sv
module link_enable #(
    parameter int LOCK_WORDS = 4,
    localparam int CW = $clog2(LOCK_WORDS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic awake,
    input  logic word_tick,
    output logic up
);
    import lsz_pkg::*;

    localparam logic [CW-1:0] LAST_CNT = CW'(LOCK_WORDS - 1);

    link_state_e   state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !awake) begin
            state <= LNK_LOCKING;
            cnt   <= '0;
        end else if (state == LNK_LOCKING && word_tick) begin
            if (cnt == LAST_CNT) begin
                state <= LNK_UP;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign up = (state == LNK_UP);

endmodule

// File: rtl/lane_serializer7.sv
module lane_serializer7 #(
    parameter int LANES      = lsz_pkg::LSZ_LANES,
    parameter int SLOTS      = lsz_pkg::LSZ_SLOTS,
    parameter int CLK_HIGH   = lsz_pkg::LSZ_CLK_HIGH,
    parameter int LOCK_WORDS = lsz_pkg::LSZ_LOCK_WORDS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sleep_n,
    input  logic [LANES*SLOTS-1:0] par_data,
    output logic                   load_tick,
    output logic [LANES-1:0]       lane_q,
    output logic                   fclk_q,
    output logic                   drive_en
);
    localparam int SW = $clog2(SLOTS);

    logic [SW-1:0]    slot_idx;
    logic             fclk_raw;
    logic             link_up;
    logic [LANES-1:0] lane_raw;

    slot_sequencer #(.SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .slot_idx  (slot_idx),
        .load_tick (load_tick),
        .fclk_raw  (fclk_raw)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            lane_shifter #(.SLOTS(SLOTS)) u_sh (
                .clk  (clk),
                .rst  (rst),
                .load (load_tick),
                .din  (par_data[k*SLOTS +: SLOTS]),
                .dout (lane_raw[k])
            );
        end
    endgenerate

    link_enable #(.LOCK_WORDS(LOCK_WORDS)) u_en (
        .clk       (clk),
        .rst       (rst),
        .awake     (sleep_n),
        .word_tick (load_tick),
        .up        (link_up)
    );

    assign drive_en = link_up & sleep_n;
    assign lane_q   = drive_en ? lane_raw : '0;
    assign fclk_q   = drive_en & fclk_raw;

endmodule

// File: rtl/lsz_checker.sv
module lsz_checker #(
    parameter int LANES = 4,
    parameter int SLOTS = 7
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sleep_n,
    input logic [LANES*SLOTS-1:0] par_data,
    input logic                   load_tick,
    input logic [LANES-1:0]       lane_q,
    input logic                   fclk_q,
    input logic                   drive_en
);
    localparam int GW = $clog2(SLOTS + 1);

    logic [GW-1:0]          gap;
    logic                   seen;
    logic [LANES*SLOTS-1:0] prev_word;
    logic [LANES-1:0]       first_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            seen      <= 1'b0;
            prev_word <= '0;
        end else begin
            prev_word <= par_data;
            if (load_tick) begin
                gap  <= '0;
                seen <= 1'b1;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            first_bits[k] = prev_word[k*SLOTS];
        end
    end

    // R1 R2
    first_slot_chk: assert property (@(posedge clk) disable iff (rst)
        load_tick && drive_en |=> !drive_en || lane_q == first_bits);

    // R3
    tick_period_chk: assert property (@(posedge clk) disable iff (rst)
        seen && load_tick |-> gap == GW'(SLOTS - 1));

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        load_tick |=> !load_tick);

    // R4
    fclk_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fclk_q) |-> $past(load_tick));

    // R5
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |-> !drive_en && lane_q == '0 && !fclk_q);

    // R6
    enable_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> $past(load_tick) && $past(sleep_n));

    // R7
    idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> lane_q == '0 && !fclk_q);

endmodule

bind lane_serializer7 lsz_checker #(.LANES(LANES), .SLOTS(SLOTS)) i_lsz_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_n   (sleep_n),
    .par_data  (par_data),
    .load_tick (load_tick),
    .lane_q    (lane_q),
    .fclk_q    (fclk_q),
    .drive_en  (drive_en)
);

// File: tb/test_lane_serializer7.sv
module test_lane_serializer7;

    localparam int LANES = 4;
    localparam int SLOTS = 7;
    localparam int LOCK  = 4;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   sleep_n = 1'b1;
    logic [LANES*SLOTS-1:0] par_data = '0;
    logic                   load_tick;
    logic [LANES-1:0]       lane_q;
    logic                   fclk_q;
    logic                   drive_en;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    lane_serializer7 i_lane_serializer7 (
        .clk       (clk),
        .rst       (rst),
        .sleep_n   (sleep_n),
        .par_data  (par_data),
        .load_tick (load_tick),
        .lane_q    (lane_q),
        .fclk_q    (fclk_q),
        .drive_en  (drive_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic align_tick();
        while (load_tick !== 1'b1) @(negedge clk);
    endtask

    // counts LOCK ticks with outputs disabled, then expects the enable
    task automatic wait_lock(input string req);
        int seen_ticks = 0;
        while (seen_ticks < LOCK) begin
            check({req, " drive_en low while locking"}, 32'(drive_en), 32'd0);
            check("R7 lanes idle while disabled", 32'({lane_q, fclk_q}), 32'd0);
            if (load_tick) seen_ticks++;
            @(negedge clk);
        end
        check({req, " drive_en high after lock"}, 32'(drive_en), 32'd1);
        check("R6 enable lands on slot 0", 32'(fclk_q), 32'd1);
    endtask

    task automatic send_word(input logic [LANES*SLOTS-1:0] d);
        align_tick();
        par_data = d;
        for (int s = 0; s < SLOTS; s++) begin
            logic [LANES-1:0] exp_l;
            @(negedge clk);
            for (int k = 0; k < LANES; k++) exp_l[k] = d[k*SLOTS + s];
            check($sformatf("R2 lanes slot %0d", s), 32'(lane_q), 32'(exp_l));
            check($sformatf("R4 fclk slot %0d", s), 32'(fclk_q), 32'(s < 4));
            check("R3 tick in last slot only", 32'(load_tick), 32'(s == SLOTS - 1));
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R8 drive_en in reset", 32'(drive_en), 32'd0);
        check("R8 outputs in reset", 32'({lane_q, fclk_q}), 32'd0);
        check("R8 no tick in reset", 32'(load_tick), 32'd0);
        rst = 1'b0;
        // slot 0 now; tick expected in the 7th cycle
        for (int c = 0; c < SLOTS; c++) begin
            check("R3 slot count after reset", 32'(load_tick), 32'(c == SLOTS - 1));
            if (c < SLOTS - 1) @(negedge clk);
        end
    endtask

    task automatic t_lock_after_reset();
        wait_lock("R6 reset");
    endtask

    task automatic t_patterns();
        send_word(28'hFFFFFFF);
        send_word(28'h0000000);
        send_word(28'h0000001);   // R1 lowest bit
        send_word(28'h8000000);   // R1 highest bit
        send_word(28'h5A5A5A5);
        send_word(28'hC3F00E1);
        for (int i = 0; i < LANES * SLOTS; i += 5) send_word(28'(1) << i);
    endtask

    task automatic t_sleep_mid_word();
        align_tick();
        par_data = 28'hFFFFFFF;
        repeat (2) @(negedge clk);
        sleep_n = 1'b0;
        #1;
        check("R5 drive_en same cycle", 32'(drive_en), 32'd0);
        check("R5 lanes same cycle", 32'({lane_q, fclk_q}), 32'd0);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            check("R5 lanes held idle", 32'({lane_q, fclk_q}), 32'd0);
            check("R5 drive_en held low", 32'(drive_en), 32'd0);
        end
        align_tick();
        @(negedge clk);
        sleep_n = 1'b1;
        wait_lock("R6 wake");
        send_word(28'h1234567);
    endtask

    task automatic t_sleep_short();
        // sleep lasting one cycle still restarts the full lock count
        align_tick();
        sleep_n = 1'b0;
        @(negedge clk);
        sleep_n = 1'b1;
        check("R7 idle after short sleep", 32'({lane_q, fclk_q}), 32'd0);
        wait_lock("R6 short sleep");
        send_word(28'hABCDEF0);
    endtask

    initial begin
        t_reset();
        t_lock_after_reset();
        t_patterns();
        t_sleep_mid_word();
        t_sleep_short();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule